// File: doc/BRIEF.md
# Comparator-Probability Slope Digitizer

This block turns a stream of single-bit comparator decisions into one digital voltage word per sampled time point, without any sample-and-hold. An external sequencer holds a reference code steady while the comparator makes a fixed number of decisions, then marks the end of that batch. The block counts how many of those decisions came out as one, which estimates the probability that the probed voltage exceeds the reference. The sequencer then steps the reference code upward and repeats.

Over a full sweep of reference codes, the block tracks the batch-to-batch rise in the ones-count and remembers the code where that rise was largest. That code is where the comparator's transition curve is steepest. When the sequencer marks the end of the sweep, the block reports the code as the digitized voltage and starts the next sweep fresh. The result is a serial stream of words, one per sweep. A flag marks sweeps in which the count never rose.

Top module: `slope_digitizer`

## Requirements
- R1: Between batch closes, the block counts the cycles with `dec_vld` and `dec_bit` both high; cycles where `dec_vld` is low are not counted, whatever `dec_bit` is. A counted decision in the same cycle as `batch_done` belongs to the batch being closed. The next batch starts from zero.
- R2: The slope of a batch is its ones-count minus the ones-count of the previous batch in the same sweep. For the first batch of a sweep, the previous count is taken as zero.
- R3: At the end of a sweep, `word` equals the `ref_code` value that was present in the `batch_done` cycle of the batch with the largest positive slope.
- R4: When several batches share the largest positive slope, the lowest of their codes is reported.
- R5: When no batch in a sweep has a slope above zero, `word` is 0 and `no_edge` is 1. Otherwise `no_edge` is 0.
- R6: If `sweep_done` is sampled high at rising edge n, then `word_vld` is high from edge n+1 to edge n+2 and is low at all other times.
- R7: A batch closed in the same cycle as `sweep_done` is part of the sweep that is ending. After a sweep ends, the next sweep starts with no remembered slope and an assumed previous count of zero.
- R8: `word` and `no_edge` hold their values in every cycle where `word_vld` is low.
- R9: While `rst_n` is low, `word_vld`, `word` and `no_edge` are 0, and any partial count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | The comparator decision is valid this cycle |
| dec_bit | input | 1 | Comparator decision (1 = probe above reference) |
| batch_done | input | 1 | Closes the batch for the current reference code |
| sweep_done | input | 1 | Closes the sweep and requests an output word |
| ref_code | input | CODE_W | Reference code in use for the current batch |
| word_vld | output | 1 | One-cycle strobe: a new word is present |
| word | output | CODE_W | Digitized voltage (code of steepest rise) |
| no_edge | output | 1 | The last sweep had no positive slope |

## Verification
Three events can coincide in one cycle: a counted decision, the close of a batch and the close of a sweep. The bench drives sweeps in which the last decision, the batch close and the sweep close all share a cycle. It also drives sweeps where they fall in separate cycles, with idle and invalid cycles in between. A behavioural model built from the requirements predicts every cycle's `word_vld`, `word` and `no_edge`. Any misplaced decision or lost final batch changes the reported code or the timing of the strobe.

// File: rtl/slope_dig_pkg.sv
package slope_dig_pkg;

    localparam int DEF_CODE_W    = 10;
    localparam int DEF_DECISIONS = 1024;

    // Ones-count width able to hold 0..n inclusive
    function automatic int cnt_width(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/sd_ones_counter.sv
module sd_ones_counter #(
    parameter int CODE_W    = 10,
    parameter int DECISIONS = 1024,
    localparam int CNT_W    = slope_dig_pkg::cnt_width(DECISIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic              dec_bit,
    input  logic              batch_done,
    input  logic              sweep_done,
    input  logic [CODE_W-1:0] ref_code,
    output logic              bat_vld,
    output logic [CNT_W-1:0]  bat_cnt,
    output logic [CODE_W-1:0] bat_code,
    output logic              swp_end
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DECISIONS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              bvld;
        logic [CNT_W-1:0]  bcnt;
        logic [CODE_W-1:0] bcode;
        logic              send;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.cnt;
        if (dec_vld && dec_bit && (st_q.cnt != FULL)) begin
            sum = st_q.cnt + 1'b1;
        end
        st_d.cnt  = sum;
        st_d.bvld = batch_done;
        st_d.send = sweep_done;
        if (batch_done) begin
            st_d.bcnt  = sum;
            st_d.bcode = ref_code;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bat_vld  = st_q.bvld;
    assign bat_cnt  = st_q.bcnt;
    assign bat_code = st_q.bcode;
    assign swp_end  = st_q.send;

endmodule

// File: rtl/sd_slope_tracker.sv
module sd_slope_tracker #(
    parameter int CODE_W = 10,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bat_vld,
    input  logic [CNT_W-1:0]  bat_cnt,
    input  logic [CODE_W-1:0] bat_code,
    input  logic              swp_end,
    output logic              res_vld,
    output logic [CODE_W-1:0] res_code,
    output logic              res_none
);

    typedef struct packed {
        logic                    first;
        logic                    has;
        logic [CNT_W-1:0]        prev;
        logic signed [CNT_W:0]   best;
        logic [CODE_W-1:0]       code;
    } trk_t;

    localparam trk_t TRK_IDLE = '{first: 1'b1, has: 1'b0, prev: '0, best: '0, code: '0};

    trk_t st_d, st_q;
    logic [CNT_W-1:0]      prev_eff;
    logic signed [CNT_W:0] slope;
    logic                  better;

    always_comb begin
        st_d     = st_q;
        prev_eff = st_q.first ? '0 : st_q.prev;
        slope    = $signed({1'b0, bat_cnt}) - $signed({1'b0, prev_eff});
        better   = (slope > 0) &&
                   (!st_q.has || (slope > st_q.best) ||
                    ((slope == st_q.best) && (bat_code < st_q.code)));
        if (bat_vld) begin
            st_d.prev  = bat_cnt;
            st_d.first = 1'b0;
            if (better) begin
                st_d.has  = 1'b1;
                st_d.best = slope;
                st_d.code = bat_code;
            end
        end
        res_vld  = swp_end;
        res_code = st_d.has ? st_d.code : '0;
        res_none = !st_d.has;
        if (swp_end) begin
            st_d = TRK_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TRK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sd_word_reg.sv
module sd_word_reg #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic [CODE_W-1:0] res_code,
    input  logic              res_none,
    output logic              word_vld,
    output logic [CODE_W-1:0] word,
    output logic              no_edge
);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] w;
        logic              none;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = res_vld;
        if (res_vld) begin
            st_d.w    = res_code;
            st_d.none = res_none;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.w;
    assign no_edge  = st_q.none;

endmodule

// File: rtl/slope_digitizer.sv
module slope_digitizer #(
    parameter int CODE_W    = slope_dig_pkg::DEF_CODE_W,
    parameter int DECISIONS = slope_dig_pkg::DEF_DECISIONS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic              dec_bit,
    input  logic              batch_done,
    input  logic              sweep_done,
    input  logic [CODE_W-1:0] ref_code,
    output logic              word_vld,
    output logic [CODE_W-1:0] word,
    output logic              no_edge
);

    localparam int CNT_W = slope_dig_pkg::cnt_width(DECISIONS);

    logic              bat_vld;
    logic [CNT_W-1:0]  bat_cnt;
    logic [CODE_W-1:0] bat_code;
    logic              swp_end;
    logic              res_vld;
    logic [CODE_W-1:0] res_code;
    logic              res_none;

    sd_ones_counter #(.CODE_W(CODE_W), .DECISIONS(DECISIONS)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(dec_vld), .dec_bit(dec_bit),
        .batch_done(batch_done), .sweep_done(sweep_done), .ref_code(ref_code),
        .bat_vld(bat_vld), .bat_cnt(bat_cnt), .bat_code(bat_code), .swp_end(swp_end)
    );

    sd_slope_tracker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .bat_vld(bat_vld), .bat_cnt(bat_cnt), .bat_code(bat_code), .swp_end(swp_end),
        .res_vld(res_vld), .res_code(res_code), .res_none(res_none)
    );

    sd_word_reg #(.CODE_W(CODE_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .res_vld(res_vld), .res_code(res_code), .res_none(res_none),
        .word_vld(word_vld), .word(word), .no_edge(no_edge)
    );

endmodule

// File: rtl/slope_digitizer_chk.sv
module slope_digitizer_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sweep_done,
    input logic              word_vld,
    input logic [CODE_W-1:0] word,
    input logic              no_edge
);

    // R6: a strobe only follows a sweep close two edges earlier
    a_r6_vld_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(sweep_done, 2));

    // R6: a sweep close always produces a strobe two edges later
    a_r6_sweep_gives_vld: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sweep_done, 2) |-> word_vld);

    // R5: a flagged result carries word zero
    a_r5_noedge_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && no_edge) |-> (word == '0));

    // R8: outputs hold between strobes
    a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> ($stable(word) && $stable(no_edge)));

    // R9: quiet outputs during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!word_vld && (word == '0) && !no_edge));

endmodule

bind slope_digitizer slope_digitizer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sweep_done(sweep_done),
    .word_vld(word_vld), .word(word), .no_edge(no_edge)
);

// File: tb/slope_digitizer_tb_top.sv
module slope_digitizer_tb_top;

    localparam int CW  = 4;
    localparam int DEC = 8;
    localparam int NC  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dec_vld = 0, dec_bit = 0, batch_done = 0, sweep_done = 0;
    logic [CW-1:0] ref_code = '0;
    logic          word_vld;
    logic [CW-1:0] word;
    logic          no_edge;

    always #2.5 clk = ~clk;

    slope_digitizer #(.CODE_W(CW), .DECISIONS(DEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_bit(dec_bit),
        .batch_done(batch_done), .sweep_done(sweep_done), .ref_code(ref_code),
        .word_vld(word_vld), .word(word), .no_edge(no_edge)
    );

    int    n_checks = 0, n_fail = 0;
    string tag = "R9";
    int    m_cnt = 0;
    int    q_cnt[$];
    int    q_code[$];
    logic  p0_v = 0, p1_v = 0, p0_n = 0, p1_n = 0, h_n = 0;
    int    p0_w = 0, p1_w = 0, h_w = 0;
    int    prof[NC];

    task automatic chk(input string t, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
        end
    endtask

    // expected result from queued batches, per R2..R5
    task automatic eval_sweep(output int w, output logic none);
        int prev = 0, bs = 0, bc = 0;
        logic has = 0;
        foreach (q_cnt[i]) begin
            int s = q_cnt[i] - prev;
            if (s > 0 && (!has || s > bs || (s == bs && q_code[i] < bc))) begin
                has = 1; bs = s; bc = q_code[i];
            end
            prev = q_cnt[i];
        end
        w = has ? bc : 0;
        none = !has;
        q_cnt.delete();
        q_code.delete();
    endtask

    task automatic step(input logic v, input logic b, input logic bd, input logic sd, input int code);
        string t;
        @(negedge clk);
        if (p1_v) begin h_w = p1_w; h_n = p1_n; end
        t = p1_v ? tag : "R8";
        chk("R6", int'(word_vld), int'(p1_v), "word_vld");
        chk(t, int'(word), h_w, "word");
        chk(t, int'(no_edge), int'(h_n), "no_edge");
        p1_v = p0_v; p1_w = p0_w; p1_n = p0_n;
        p0_v = 0;
        dec_vld = v; dec_bit = b; batch_done = bd; sweep_done = sd;
        ref_code = CW'(code);
        if (v && b) m_cnt++;
        if (bd) begin q_cnt.push_back(m_cnt); q_code.push_back(code); m_cnt = 0; end
        if (sd) begin
            p0_v = 1;
            eval_sweep(p0_w, p0_n);
        end
    endtask

    // gaps: insert invalid cycles with dec_bit high; sb: separate batch close; ss: separate sweep close
    task automatic run_sweep(input int ncodes, input logic gaps, input logic sb, input logic ss);
        for (int c = 0; c < ncodes; c++) begin
            for (int j = 0; j < DEC; j++) begin
                logic b = (((j * 5 + c) % DEC) < prof[c]);
                logic last = (j == DEC - 1);
                logic lastc = last && (c == ncodes - 1);
                if (gaps && (j % 3 == 1)) step(0, 1, 0, 0, c);
                if (last && sb) begin
                    step(1, b, 0, 0, c);
                    step(0, 1, 1, lastc && !ss, c);
                end else begin
                    step(1, b, last, lastc && !ss, c);
                end
            end
        end
        if (ss) step(0, 0, 0, 1, ncodes - 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", int'(word_vld), 0, "word_vld in reset");
        chk("R9", int'(word), 0, "word in reset");
        chk("R9", int'(no_edge), 0, "no_edge in reset");
        // partial count during reset must be discarded
        dec_vld = 1; dec_bit = 1;
        @(negedge clk);
        rst_n = 1'b1;
        dec_vld = 0; dec_bit = 0;

        // R3: single sharp step at code 5, all closes coincide (R1, R7)
        tag = "R3";
        foreach (prof[i]) prof[i] = (i < 5) ? 0 : DEC;
        run_sweep(NC, 0, 0, 0);

        // R3: gradual ramp with a steeper jump at code 9, with gaps (R1)
        tag = "R3";
        foreach (prof[i]) prof[i] = (i < 3) ? 0 : (i < 9 ? 1 : (i < 12 ? 5 : DEC));
        run_sweep(NC, 1, 0, 0);

        // R4: equal rises of 3 at codes 4 and 10
        tag = "R4";
        foreach (prof[i]) prof[i] = (i < 4) ? 0 : (i < 10 ? 3 : 6);
        run_sweep(NC, 0, 1, 0);

        // R5: flat zero, no rise anywhere
        tag = "R5";
        foreach (prof[i]) prof[i] = 0;
        run_sweep(NC, 1, 1, 1);

        // R2: full from the first code, rise against assumed zero -> code 0, flag low
        tag = "R2";
        foreach (prof[i]) prof[i] = DEC;
        run_sweep(NC, 0, 0, 1);

        // R2: falling curve, only the first batch rises
        tag = "R2";
        foreach (prof[i]) prof[i] = (i < 2) ? 6 : 2;
        run_sweep(NC, 0, 1, 1);

        // R7: steepest rise in the batch closing with the sweep
        tag = "R7";
        foreach (prof[i]) prof[i] = (i < NC - 1) ? 1 : DEC;
        run_sweep(NC, 0, 0, 0);
        // R7: next sweep must not inherit; previous is zero again
        foreach (prof[i]) prof[i] = 2;
        run_sweep(4, 1, 0, 0);

        // R1: back-to-back short sweeps with mixed framing
        tag = "R1";
        for (int r = 0; r < 12; r++) begin
            foreach (prof[i]) prof[i] = $urandom_range(0, DEC);
            run_sweep(NC, r[0], r[1], r[2]);
        end

        tag = "R6";
        repeat (4) step(0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule